// File: doc/BRIEF.md
# Lockable Watchdog with Slow-Domain Register Transfer

This block is a watchdog timer. Its counter runs on a slow, low-frequency clock, and software configures it through a small register port clocked by the fast bus clock. A control write and a command write do not take effect at once. Each one is handed to the slow domain by its own toggle handshake. A status register shows, with one bit per register, which of those transfers has not yet been acknowledged. The bus side holds the written word and keeps it stable while the slow side copies it.

Software keeps the watchdog alive by writing the clear command, which resets the slow counter to zero. If the counter runs to the selected period while the watchdog is enabled, the slow side flips a timeout toggle. The bus side turns that toggle into a one-cycle reset-request pulse. A lock bit in the control word freezes the whole control register until the next reset. Once it is set, even a write that tries to disable the watchdog is ignored. The 2-bit clock-select field is applied in the slow domain and driven out to an external clock mux.

Top module: `slowdom_watchdog`

## Requirements
- R1: A control write (address 0) that is accepted sets status bit 0 (control busy) on the next bus cycle. The bit clears by itself once the slow domain acknowledges. The `clk_sel` output takes the new clock-select value (control bits 7:6) only after the transfer lands, never on the cycle after the write.
- R2: Writing address 1 with data bit 0 set issues a clear command. It sets status bit 1 (command busy) on the next cycle and leaves status bit 0 unchanged. The bit clears by itself after the acknowledge returns.
- R3: A control write that arrives while status bit 0 is set is discarded. Reading address 0 still returns the earlier value.
- R4: Clear commands that arrive more often than the timeout period keep `rst_req` low. Once the clear commands stop, `rst_req` pulses again.
- R5: With the watchdog enabled and no clear commands, `rst_req` goes high for exactly one bus cycle once every 2^(n+3)+1 slow-clock cycles. Here n is the period code in control bits 11:8.
- R6: Once lock (control bit 12) is set, every later control write is ignored, including one that clears enable. The status register does not go busy for such a write, the read-back value is unchanged, and the watchdog keeps firing.
- R7: Lock may be set while the watchdog is disabled. A later write that tries to enable it is then ignored, and `rst_req` stays low.
- R8: While enable (control bit 0) is low in the slow domain, `rst_req` never pulses.
- R9: After reset the control register reads 0, the status register reads 0, `clk_sel` is 0 and `rst_req` is low. Reset also clears the lock.
- R10: Address 0 reads back every control field: bit 0 enable, bit 1 run in debug, bits 2 and 3 run in low-power modes, bit 4 block low-power entry, bit 5 block oscillator disable, bits 7:6 clock select, bits 11:8 period, bit 12 lock. Address 1 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast register-port clock |
| lf_clk | input | 1 | Slow watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| addr | input | 2 | Register address: 0 control, 1 command, 2 status |
| wdata | input | 13 | Write data |
| rdata | output | 13 | Read data for the addressed register (combinational) |
| clk_sel | output | 2 | Clock select as applied in the slow domain |
| rst_req | output | 1 | One-cycle reset request in the bus domain |

## Verification
The bench writes a second control word while the first one is still in flight. A design without the busy drop would overwrite the held word and corrupt the value the slow side copies. It measures the spacing of `rst_req` pulses for two period codes. A period formula that is off by one, or a counter that does not wrap, shows up there as a wrong gap, and a stretched pulse is caught as a two-cycle request. It tries to disable a locked watchdog, and to enable one that was locked while disabled. A lock that is not sticky, or that only guards the enable bit, would then change the read-back value or the firing behaviour. It also checks `clk_sel` on the cycle right after a write, to catch a design that applies the configuration before the handshake completes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PER_W     = 4;
  localparam int CSEL_W    = 2;
  localparam int F_EN      = 0;
  localparam int F_CSEL_LO = 6;
  localparam int F_PER_LO  = F_CSEL_LO + CSEL_W;
  localparam int F_LOCK    = F_PER_LO + PER_W;
  localparam int DW        = F_LOCK + 1;
  localparam int CNT_W     = (1 << PER_W) + 3;
  localparam int N_SYNC    = 3;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  // number of slow cycles between timeouts for period code per
  function automatic logic [CNT_W-1:0] wdt_limit(input logic [PER_W-1:0] per);
    logic [CNT_W-1:0] v;
    v = CNT_W'(1) << (32'(per) + 3);
    return v + CNT_W'(1);
  endfunction
endpackage

// File: rtl/wdt_sync2.sv
module wdt_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/wdt_bus_side.sv
module wdt_bus_side
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              cfg_en,
  output logic [CSEL_W-1:0] cfg_csel,
  output logic [PER_W-1:0]  cfg_per,
  output logic              ctrl_req_tgl,
  output logic              cmd_req_tgl,
  input  logic              ctrl_ack_tgl,
  input  logic              cmd_ack_tgl,
  input  logic              tmo_tgl,
  output logic              rst_req
);
  logic [DW-1:0]     ctrl_q;
  logic [N_SYNC-1:0] async_in;
  logic [N_SYNC-1:0] sync_out;
  logic              tmo_seen;
  logic              ctrl_busy, cmd_busy, locked;
  logic              ctrl_wr, ctrl_take, cmd_take;

  assign async_in = {tmo_tgl, cmd_ack_tgl, ctrl_ack_tgl};

  for (genvar i = 0; i < N_SYNC; i++) begin : g_sync
    wdt_sync2 u_sync (.clk(clk), .rst_n(rst_n), .d(async_in[i]), .q(sync_out[i]));
  end

  assign ctrl_busy = ctrl_req_tgl ^ sync_out[0];
  assign cmd_busy  = cmd_req_tgl ^ sync_out[1];
  assign locked    = ctrl_q[F_LOCK];
  assign ctrl_wr   = wr_en && (addr == A_CTRL);
  assign ctrl_take = ctrl_wr && !ctrl_busy && !locked;
  assign cmd_take  = wr_en && (addr == A_CMD) && wdata[0] && !cmd_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q       <= '0;
      ctrl_req_tgl <= 1'b0;
      cmd_req_tgl  <= 1'b0;
      tmo_seen     <= 1'b0;
    end else begin
      if (ctrl_take) begin
        ctrl_q       <= wdata;
        ctrl_req_tgl <= ~ctrl_req_tgl;
      end
      if (cmd_take) cmd_req_tgl <= ~cmd_req_tgl;
      tmo_seen <= sync_out[2];
    end
  end

  assign rst_req  = sync_out[2] ^ tmo_seen;
  assign cfg_en   = ctrl_q[F_EN];
  assign cfg_csel = ctrl_q[F_CSEL_LO +: CSEL_W];
  assign cfg_per  = ctrl_q[F_PER_LO +: PER_W];

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata = ctrl_q;
      A_STAT: begin
        rdata[0] = ctrl_busy;
        rdata[1] = cmd_busy;
      end
      default: rdata = '0;
    endcase
  end

  assert_busy_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_take |=> ctrl_busy);
  assert_cmd_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |=> cmd_busy);
  assert_drop_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_busy) |=> $stable(ctrl_q));
  assert_pulse_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(ctrl_q) && $stable(ctrl_req_tgl)));
endmodule

// File: rtl/wdt_lf_core.sv
module wdt_lf_core
  import wdt_pkg::*;
(
  input  logic              lf_clk,
  input  logic              rst_n,
  input  logic              ctrl_req_tgl,
  input  logic              cmd_req_tgl,
  input  logic              cfg_en,
  input  logic [CSEL_W-1:0] cfg_csel,
  input  logic [PER_W-1:0]  cfg_per,
  output logic              ctrl_ack_tgl,
  output logic              cmd_ack_tgl,
  output logic              tmo_tgl,
  output logic [CSEL_W-1:0] clk_sel
);
  logic [1:0]       req_in, req_s;
  logic             en_q;
  logic [PER_W-1:0] per_q;
  logic [CNT_W-1:0] cnt, lim_m1;
  logic             ctrl_land, clear_evt, tmo_evt;

  assign req_in = {cmd_req_tgl, ctrl_req_tgl};

  for (genvar i = 0; i < 2; i++) begin : g_req
    wdt_sync2 u_sync (.clk(lf_clk), .rst_n(rst_n), .d(req_in[i]), .q(req_s[i]));
  end

  assign ctrl_land = req_s[0] ^ ctrl_ack_tgl;
  assign clear_evt = req_s[1] ^ cmd_ack_tgl;
  assign lim_m1    = wdt_limit(per_q) - CNT_W'(1);
  assign tmo_evt   = en_q && !clear_evt && (cnt >= lim_m1);

  always_ff @(posedge lf_clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_ack_tgl <= 1'b0;
      cmd_ack_tgl  <= 1'b0;
      en_q         <= 1'b0;
      per_q        <= '0;
      clk_sel      <= '0;
      cnt          <= '0;
      tmo_tgl      <= 1'b0;
    end else begin
      ctrl_ack_tgl <= req_s[0];
      cmd_ack_tgl  <= req_s[1];
      if (ctrl_land) begin
        en_q    <= cfg_en;
        per_q   <= cfg_per;
        clk_sel <= cfg_csel;
      end
      if (!en_q || clear_evt) begin
        cnt <= '0;
      end else if (tmo_evt) begin
        cnt     <= '0;
        tmo_tgl <= ~tmo_tgl;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assert_clear_zero_R4: assert property (@(posedge lf_clk) disable iff (!rst_n)
    clear_evt |=> (cnt == '0));
  assert_idle_quiet_R8: assert property (@(posedge lf_clk) disable iff (!rst_n)
    !en_q |=> $stable(tmo_tgl));
  assert_cfg_hold_R1: assert property (@(posedge lf_clk) disable iff (!rst_n)
    !ctrl_land |=> $stable(clk_sel));
endmodule

// File: rtl/slowdom_watchdog.sv
module slowdom_watchdog
  import wdt_pkg::*;
(
  input  logic              bus_clk,
  input  logic              lf_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [CSEL_W-1:0] clk_sel,
  output logic              rst_req
);
  logic              cfg_en;
  logic [CSEL_W-1:0] cfg_csel;
  logic [PER_W-1:0]  cfg_per;
  logic              ctrl_req_tgl, cmd_req_tgl;
  logic              ctrl_ack_tgl, cmd_ack_tgl, tmo_tgl;

  wdt_bus_side u_bus (
    .clk(bus_clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cfg_en(cfg_en), .cfg_csel(cfg_csel), .cfg_per(cfg_per),
    .ctrl_req_tgl(ctrl_req_tgl), .cmd_req_tgl(cmd_req_tgl),
    .ctrl_ack_tgl(ctrl_ack_tgl), .cmd_ack_tgl(cmd_ack_tgl),
    .tmo_tgl(tmo_tgl), .rst_req(rst_req)
  );

  wdt_lf_core u_lf (
    .lf_clk(lf_clk), .rst_n(rst_n), .ctrl_req_tgl(ctrl_req_tgl),
    .cmd_req_tgl(cmd_req_tgl), .cfg_en(cfg_en), .cfg_csel(cfg_csel),
    .cfg_per(cfg_per), .ctrl_ack_tgl(ctrl_ack_tgl), .cmd_ack_tgl(cmd_ack_tgl),
    .tmo_tgl(tmo_tgl), .clk_sel(clk_sel)
  );
endmodule

// File: tb/slowdom_watchdog_bench.sv
module slowdom_watchdog_bench;
  logic        bus_clk = 1'b0;
  logic        lf_clk  = 1'b0;
  logic        rst_n   = 1'b0;
  logic        wr_en   = 1'b0;
  logic [1:0]  addr    = 2'd0;
  logic [12:0] wdata   = '0;
  logic [12:0] rdata;
  logic [1:0]  clk_sel;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulse_cnt = 0;
  int last_cyc = 0;
  bit arm_req = 0;
  bit armed = 0;
  bit prev_req = 0;
  int exp_q[$];

  slowdom_watchdog u_slowdom_watchdog (
    .bus_clk(bus_clk), .lf_clk(lf_clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .clk_sel(clk_sel), .rst_req(rst_req)
  );

  always #4 bus_clk = ~bus_clk;          // 125 MHz
  initial begin #2; forever #20 lf_clk = ~lf_clk; end  // 5 bus cycles per slow cycle

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int gap_bus(input int per);
    return ((1 << (per + 3)) + 1) * 5;
  endfunction

  // monitor: pulse width, pulse counting and scoreboard of pulse gaps
  always @(negedge bus_clk) begin
    cyc++;
    if (rst_req && prev_req) chk("R5 pulse width", 2, 1);
    if (rst_req) begin
      pulse_cnt++;
      if (arm_req) begin
        arm_req = 0; armed = 1; last_cyc = cyc;
      end else if (armed && exp_q.size() > 0) begin
        chk("R5 gap", cyc - last_cyc, exp_q.pop_front());
        last_cyc = cyc;
        if (exp_q.size() == 0) armed = 0;
      end
    end
    prev_req = rst_req;
  end

  task automatic wr(input logic [1:0] a, input logic [12:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a; #1; v = int'(rdata);
  endtask

  task automatic wait_idle(input string req);
    int v;
    for (int i = 0; i < 80; i++) begin
      rd(2'd2, v);
      if (v == 0) break;
      @(negedge bus_clk);
    end
    rd(2'd2, v);
    chk(req, v, 0);
  endtask

  task automatic wait_pulse();
    int p;
    p = pulse_cnt;
    while (pulse_cnt == p) @(negedge bus_clk);
  endtask

  task automatic expect_gaps(input int n, input int per);
    wait_pulse(); wait_pulse();
    arm_req = 1;
    for (int i = 0; i < n; i++) exp_q.push_back(gap_bus(per));
    while (exp_q.size() > 0 || arm_req) @(negedge bus_clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge bus_clk);
    rst_n = 1'b1;
    @(negedge bus_clk);
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, p;
    do_reset();
    // R9 reset state
    rd(2'd0, v); chk("R9 ctrl", v, 0);
    rd(2'd2, v); chk("R9 status", v, 0);
    chk("R9 clk_sel", int'(clk_sel), 0);
    chk("R9 rst_req", int'(rst_req), 0);

    // R1 / R3: control transfer, busy drop
    wr(2'd0, 13'h082);
    rd(2'd2, v); chk("R1 busy set", v, 1);
    chk("R1 clk_sel not yet", int'(clk_sel), 0);
    wr(2'd0, 13'h03C);
    rd(2'd0, v); chk("R3 dropped write", v, 13'h082);
    wait_idle("R1 busy clears");
    chk("R1 clk_sel applied", int'(clk_sel), 2);
    rd(2'd0, v); chk("R10 readback", v, 13'h082);
    rd(2'd1, v); chk("R10 cmd reads zero", v, 0);

    // R8 disabled: no pulses
    p = pulse_cnt;
    repeat (300) @(negedge bus_clk);
    chk("R8 no pulse disabled", pulse_cnt - p, 0);

    // R2 command busy
    wr(2'd1, 13'h001);
    rd(2'd2, v); chk("R2 cmd busy only", v, 2);
    wait_idle("R2 cmd busy clears");

    // R5 period 0 and 1
    wr(2'd0, 13'h03F);
    wait_idle("R5 en landed");
    rd(2'd0, v); chk("R10 all low fields", v, 13'h03F);
    expect_gaps(3, 0);
    wr(2'd0, 13'h101);
    wait_idle("R5 per1 landed");
    expect_gaps(2, 1);

    // R4 feeding prevents reset
    repeat (4) begin wr(2'd1, 13'h001); repeat (24) @(negedge bus_clk); end
    p = pulse_cnt;
    repeat (16) begin wr(2'd1, 13'h001); repeat (24) @(negedge bus_clk); end
    chk("R4 fed no pulse", pulse_cnt - p, 0);
    p = pulse_cnt;
    repeat (200) @(negedge bus_clk);
    chk("R4 unfed fires", int'(pulse_cnt - p > 0), 1);

    // R6 lock while enabled
    wr(2'd0, 13'h1101);
    wait_idle("R6 lock landed");
    wr(2'd0, 13'h0000);
    rd(2'd2, v); chk("R6 locked write no busy", v, 0);
    rd(2'd0, v); chk("R6 locked readback", v, 13'h1101);
    p = pulse_cnt;
    repeat (200) @(negedge bus_clk);
    chk("R6 still fires", int'(pulse_cnt - p > 0), 1);

    // R9 reset clears lock, R7 lock while disabled
    do_reset();
    rd(2'd0, v); chk("R9 lock cleared", v, 0);
    wr(2'd0, 13'h1000);
    wait_idle("R7 lock landed");
    wr(2'd0, 13'h0001);
    rd(2'd0, v); chk("R7 enable ignored", v, 13'h1000);
    p = pulse_cnt;
    repeat (300) @(negedge bus_clk);
    chk("R7 no pulse", pulse_cnt - p, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule